// File: doc/BRIEF.md
# AHB Master Burst Address Sequencer

This block runs the address and control phase of an AHB bus master that serves a cached processor. The cache and write-buffer side hands it one request at a time: a start address, a transfer kind, a direction and an access size. The block picks the burst type from the kind, forces word size on burst beats, and steps the beat addresses. It drives the transfer type, address, burst, size and direction onto the bus, and it holds them while the slave stalls.

Request kinds are coded on `reqKind` as follows: 0 single access, 1 half-line write-back, 2 full-line write-back, 3 cache linefill, 4 four-word write, 5 eight-word write, 6 instruction prefetch. Code 7 is treated as a single access. The block keeps track of which beat sits in the data phase. If the bus is taken away in the middle of a burst, or a beat is answered with RETRY or SPLIT, the block does not start a new burst. It completes the remaining beats one by one as single transfers. After a RETRY or SPLIT, the beat that failed is the first one sent again.

Top module: `ahb_burst_sequencer`

## Requirements
- R1: A linefill (kind 3) is a read issued as WRAP8 (burst 100). It has eight beats that step by 4 and wrap inside the 32-byte block holding the start address.
- R2: A full-line write-back (kind 2) or eight-word write (kind 5) is a write issued as INCR8 (burst 101) of eight beats.
- R3: A half-line write-back (kind 1) or four-word write (kind 4) is a write issued as INCR4 (burst 011) of four beats. An instruction prefetch (kind 6) is a read with the same burst.
- R4: Every beat of a burst has size 010 (word), whatever `reqSize` holds, and address bits 1:0 forced to zero.
- R5: A single access (kind 0) is one NONSEQ beat with burst 000. It uses the exact request address, the direction from `reqWrite`, and the size from `reqSize` (00 byte, 01 halfword, 10 word).
- R6: INCR4 and INCR8 may start at any word address. Each later beat adds 4, and a burst may cross a 16- or 32-byte boundary.
- R7: Transfer type is NONSEQ (10) on the first beat and SEQ (11) on the later beats of an unbroken burst. It is IDLE (00) when nothing is pending.
- R8: While `busReady` is low with a transfer pending, the address and control stay unchanged in the next cycle.
- R9: While `busGrant` is low the transfer type is IDLE. Once a burst has issued a beat and then loses the grant, every remaining beat goes out as NONSEQ with burst 000.
- R10: A RETRY (10) or SPLIT (11) response in the stalled first cycle makes the next cycle IDLE. The failed beat is then reissued at its own address as NONSEQ single, followed by the remaining beats as singles.
- R11: `reqReady` is high, and a request is taken, only when no request is in progress. It drops the cycle after acceptance and returns once the last beat's data phase ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle; request is taken when both are high |
| reqAddr | input | 32 | Start address |
| reqKind | input | 3 | Transfer kind code |
| reqWrite | input | 1 | Direction of single accesses (1 write) |
| reqSize | input | 2 | Size of single accesses |
| busGrant | input | 1 | Bus ownership granted |
| busReady | input | 1 | Slave ready |
| busResp | input | 2 | Slave response (00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT) |
| busTrans | output | 2 | Transfer type |
| busAddr | output | 32 | Beat address |
| busBurst | output | 3 | Burst type |
| busSize | output | 3 | Beat size |
| busWrite | output | 1 | Beat direction |

## Verification
The bench targets linefills that start mid-line and incrementing bursts that start near a 32-byte boundary. A design that mixes up wrap and increment would leave the block or stay in it at the wrong beat. Grant is withdrawn after two beats of a burst. A design that stays in burst mode would show SEQ or a burst code on the resumed beats. RETRY and SPLIT are injected on the third beat's data phase. A design that does not rewind would skip the failed address or resume with SEQ, and one that ignores the two-cycle response would not show IDLE in the second cycle. Random stalls check that address and control hold still while the slave waits.

// File: rtl/ahbseq_pkg.sv
package ahbseq_pkg;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic [2:0] BU_SINGLE = 3'b000;
  localparam logic [2:0] BU_INCR4  = 3'b011;
  localparam logic [2:0] BU_WRAP8  = 3'b100;
  localparam logic [2:0] BU_INCR8  = 3'b101;

  localparam logic [1:0] RS_OKAY  = 2'b00;
  localparam logic [1:0] RS_RETRY = 2'b10;
  localparam logic [1:0] RS_SPLIT = 2'b11;

  localparam logic [2:0] KD_SINGLE   = 3'd0;
  localparam logic [2:0] KD_HALF_WB  = 3'd1;
  localparam logic [2:0] KD_FULL_WB  = 3'd2;
  localparam logic [2:0] KD_LINEFILL = 3'd3;
  localparam logic [2:0] KD_WRITE4   = 3'd4;
  localparam logic [2:0] KD_WRITE8   = 3'd5;
  localparam logic [2:0] KD_PREFETCH = 3'd6;

  localparam int LINE_BEATS = 8;
  localparam int IDX_W      = $clog2(LINE_BEATS) + 1;
  localparam int WRAP_LSB   = $clog2(LINE_BEATS) + 2;

  typedef enum logic [1:0] {
    ST_IDLE, ST_ACTIVE, ST_DRAIN, ST_HOLDOFF
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic rewind;
    logic fallback;
  } seqStrobe_t;

  typedef struct packed {
    logic [2:0]       burst;
    logic [IDX_W-1:0] beats;
    logic             forceWrite;
    logic             forceRead;
  } kindInfo_t;

  function automatic kindInfo_t decodeKind(input logic [2:0] kind);
    kindInfo_t k;
    k = '{burst: BU_SINGLE, beats: IDX_W'(1), forceWrite: 1'b0, forceRead: 1'b0};
    case (kind)
      KD_HALF_WB, KD_WRITE4: k = '{BU_INCR4, IDX_W'(LINE_BEATS/2), 1'b1, 1'b0};
      KD_PREFETCH:           k = '{BU_INCR4, IDX_W'(LINE_BEATS/2), 1'b0, 1'b1};
      KD_FULL_WB, KD_WRITE8: k = '{BU_INCR8, IDX_W'(LINE_BEATS), 1'b1, 1'b0};
      KD_LINEFILL:           k = '{BU_WRAP8, IDX_W'(LINE_BEATS), 1'b0, 1'b1};
      default: ;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/ahbseq_datapath.sv
module ahbseq_datapath
  import ahbseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqKind,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  output logic [ADDR_W-1:0] busAddr,
  output logic [2:0]        busBurst,
  output logic [2:0]        busSize,
  output logic              busWrite,
  output logic              lastBeat,
  output logic              firstBeat,
  output logic              isBurst
);

  localparam int OFF_W = WRAP_LSB - 2;

  kindInfo_t         info;
  logic [ADDR_W-1:0] startAddr;
  logic [2:0]        burstCode;
  logic [IDX_W-1:0]  beatCount;
  logic [IDX_W-1:0]  beatIdx;
  logic [IDX_W-1:0]  dataIdx;
  logic [1:0]        sizeReg;
  logic              writeReg;
  logic [OFF_W-1:0]  wrapOff;
  logic [ADDR_W-1:0] incrAddr;
  logic [ADDR_W-1:0] wrapAddr;

  assign info = decodeKind(reqKind);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      burstCode <= BU_SINGLE;
      beatCount <= IDX_W'(1);
      beatIdx   <= '0;
      dataIdx   <= '0;
      sizeReg   <= 2'b00;
      writeReg  <= 1'b0;
    end else if (strb.load) begin
      burstCode <= info.burst;
      beatCount <= info.beats;
      beatIdx   <= '0;
      if (info.burst != BU_SINGLE) begin
        startAddr <= {reqAddr[ADDR_W-1:2], 2'b00};
        sizeReg   <= 2'b10;
      end else begin
        startAddr <= reqAddr;
        sizeReg   <= reqSize;
      end
      writeReg <= info.forceWrite | (reqWrite & ~info.forceRead);
    end else if (strb.rewind) begin
      beatIdx <= dataIdx;
    end else if (strb.advance) begin
      dataIdx <= beatIdx;
      beatIdx <= beatIdx + IDX_W'(1);
    end
  end

  assign wrapOff  = startAddr[WRAP_LSB-1:2] + beatIdx[OFF_W-1:0];
  assign wrapAddr = {startAddr[ADDR_W-1:WRAP_LSB], wrapOff, 2'b00};
  assign incrAddr = startAddr + (ADDR_W'(beatIdx) << 2);

  assign busAddr   = (burstCode == BU_WRAP8) ? wrapAddr : incrAddr;
  assign busBurst  = strb.fallback ? BU_SINGLE : burstCode;
  assign busSize   = {1'b0, sizeReg};
  assign busWrite  = writeReg;
  assign lastBeat  = (beatIdx == beatCount - IDX_W'(1));
  assign firstBeat = (beatIdx == '0);
  assign isBurst   = (burstCode != BU_SINGLE);

endmodule

// File: rtl/ahbseq_ctrl.sv
module ahbseq_ctrl
  import ahbseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       busGrant,
  input  logic       busReady,
  input  logic [1:0] busResp,
  input  logic       lastBeat,
  input  logic       firstBeat,
  input  logic       isBurst,
  output seqStrobe_t strb,
  output logic [1:0] busTrans,
  output logic       reqReady
);

  seqState_t state;
  logic      dataValid;
  logic      fallback;
  logic      issued;
  logic      retryHit;

  assign issued   = (state == ST_ACTIVE) && busGrant && busReady;
  assign retryHit = dataValid && !busReady &&
                    ((busResp == RS_RETRY) || (busResp == RS_SPLIT));

  always_comb begin
    strb.load     = (state == ST_IDLE) && reqValid;
    strb.rewind   = retryHit;
    strb.advance  = issued;
    strb.fallback = fallback;
  end

  always_comb begin
    busTrans = TR_IDLE;
    if (state == ST_ACTIVE && busGrant)
      busTrans = (fallback || firstBeat) ? TR_NONSEQ : TR_SEQ;
  end

  assign reqReady = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      dataValid <= 1'b0;
      fallback  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          dataValid <= 1'b0;
          if (reqValid) begin
            state    <= ST_ACTIVE;
            fallback <= 1'b0;
          end
        end
        ST_ACTIVE: begin
          if (retryHit) begin
            state     <= ST_HOLDOFF;
            fallback  <= 1'b1;
            dataValid <= 1'b0;
          end else begin
            if (busReady) dataValid <= issued;
            if (issued && lastBeat) state <= ST_DRAIN;
            if (!busGrant && !firstBeat && isBurst) fallback <= 1'b1;
          end
        end
        ST_DRAIN: begin
          if (retryHit) begin
            state     <= ST_HOLDOFF;
            fallback  <= 1'b1;
            dataValid <= 1'b0;
          end else if (busReady) begin
            state     <= ST_IDLE;
            dataValid <= 1'b0;
          end
        end
        ST_HOLDOFF: state <= ST_ACTIVE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ahb_burst_sequencer.sv
module ahb_burst_sequencer
  import ahbseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqKind,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic              busGrant,
  input  logic              busReady,
  input  logic [1:0]        busResp,
  output logic [1:0]        busTrans,
  output logic [ADDR_W-1:0] busAddr,
  output logic [2:0]        busBurst,
  output logic [2:0]        busSize,
  output logic              busWrite
);

  seqStrobe_t strb;
  logic       lastBeat;
  logic       firstBeat;
  logic       isBurst;

  ahbseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .busGrant(busGrant), .busReady(busReady), .busResp(busResp),
    .lastBeat(lastBeat), .firstBeat(firstBeat), .isBurst(isBurst),
    .strb(strb), .busTrans(busTrans), .reqReady(reqReady)
  );

  ahbseq_datapath #(.ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqKind(reqKind), .reqWrite(reqWrite), .reqSize(reqSize),
    .busAddr(busAddr), .busBurst(busBurst), .busSize(busSize), .busWrite(busWrite),
    .lastBeat(lastBeat), .firstBeat(firstBeat), .isBurst(isBurst)
  );

endmodule

// File: rtl/ahbseq_checker.sv
module ahbseq_checker
  import ahbseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              busGrant,
  input logic              busReady,
  input logic [1:0]        busResp,
  input logic [1:0]        busTrans,
  input logic [ADDR_W-1:0] busAddr,
  input logic [2:0]        busBurst,
  input logic [2:0]        busSize
);

  AST_BURST_WORD_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (busTrans[1] && busBurst != BU_SINGLE) |-> (busSize == 3'b010)); // R4

  AST_SEQ_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    (busTrans == TR_SEQ) |-> (busBurst != BU_SINGLE)); // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busTrans[1] && !busReady && busResp == RS_OKAY) |=> $stable(busAddr)); // R8

  AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busGrant |-> (busTrans == TR_IDLE)); // R9

  AST_RETRY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busReady && busResp[1]) |=> (busTrans == TR_IDLE)); // R10

  AST_WRAP_IN_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (busTrans == TR_SEQ && busBurst == BU_WRAP8 && busReady) |=>
      (busAddr[ADDR_W-1:WRAP_LSB] == $past(busAddr[ADDR_W-1:WRAP_LSB]))); // R1

  AST_READY_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (busTrans == TR_IDLE)); // R11

endmodule

bind ahb_burst_sequencer ahbseq_checker #(.ADDR_W(ADDR_W)) uChecker (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .busGrant(busGrant),
  .busReady(busReady), .busResp(busResp), .busTrans(busTrans),
  .busAddr(busAddr), .busBurst(busBurst), .busSize(busSize)
);

// File: tb/tb_ahb_burst_sequencer.sv
module tb_ahb_burst_sequencer;
  import ahbseq_pkg::*;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [31:0] reqAddr;
  logic [2:0]  reqKind;
  logic        reqWrite;
  logic [1:0]  reqSize;
  logic        busGrant;
  logic        busReady;
  logic [1:0]  busResp;
  logic [1:0]  busTrans;
  logic [31:0] busAddr;
  logic [2:0]  busBurst;
  logic [2:0]  busSize;
  logic        busWrite;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  ahb_burst_sequencer dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqKind(reqKind), .reqWrite(reqWrite), .reqSize(reqSize),
    .busGrant(busGrant), .busReady(busReady), .busResp(busResp),
    .busTrans(busTrans), .busAddr(busAddr), .busBurst(busBurst),
    .busSize(busSize), .busWrite(busWrite)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] expBurst(input logic [2:0] k);
    case (k)
      KD_HALF_WB, KD_WRITE4, KD_PREFETCH: return 3'b011;
      KD_FULL_WB, KD_WRITE8:              return 3'b101;
      KD_LINEFILL:                        return 3'b100;
      default:                            return 3'b000;
    endcase
  endfunction

  function automatic int expBeats(input logic [2:0] k);
    case (expBurst(k))
      3'b011:  return 4;
      3'b000:  return 1;
      default: return 8;
    endcase
  endfunction

  function automatic logic expWrite(input logic [2:0] k, input logic w);
    case (k)
      KD_HALF_WB, KD_FULL_WB, KD_WRITE4, KD_WRITE8: return 1'b1;
      KD_LINEFILL, KD_PREFETCH:                     return 1'b0;
      default:                                      return w;
    endcase
  endfunction

  function automatic logic [31:0] expAddr(input logic [2:0] k, input logic [31:0] a, input int i);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    if (expBurst(k) == 3'b000) return a;
    if (expBurst(k) == 3'b100) return {w[31:5], w[4:0] + 5'(i * 4)};
    return w + 32'(i * 4);
  endfunction

  function automatic string kindTag(input logic [2:0] k);
    case (expBurst(k))
      3'b100:  return "R1";
      3'b101:  return "R2";
      3'b011:  return "R3";
      default: return "R5";
    endcase
  endfunction

  // mode: 0 normal, 1 grant drop after two beats, 2 RETRY on third beat, 3 SPLIT on third beat
  task automatic runReq(input logic [31:0] a, input logic [2:0] k, input logic w,
                        input logic [1:0] sz, input int mode);
    int    n;
    int    expIdx;
    int    dataIdx;
    int    guard;
    int    dropCnt;
    bit    dataPend;
    bit    fallback;
    bit    done;
    string tg;
    logic [1:0]  eTrans;
    logic [2:0]  eSize;
    n = expBeats(k);
    tg = kindTag(k);
    expIdx = 0; dataIdx = 0; guard = 0; dropCnt = 0;
    dataPend = 0; fallback = 0; done = 0;
    eSize = (n > 1) ? 3'b010 : {1'b0, sz};
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqKind = k; reqWrite = w; reqSize = sz;
    busGrant = 1'b1; busReady = 1'b1; busResp = RS_OKAY;
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr = $urandom; reqKind = 3'($urandom % 7); reqSize = 2'($urandom % 3);
    #1 check(reqReady == 1'b0, "R11", "reqReady while busy", 32'(reqReady), 32'h0);
    while (!(expIdx == n && !dataPend) && guard < 400) begin
      guard++;
      if (mode >= 2 && !done && dataPend && dataIdx == 2) begin
        busGrant = 1'b1; busReady = 1'b0; busResp = (mode == 2) ? RS_RETRY : RS_SPLIT;
        @(negedge clk);
        busReady = 1'b1;
        #1 check(busTrans == TR_IDLE, "R10", "trans in second response cycle",
                 32'(busTrans), 32'(TR_IDLE));
        @(negedge clk);
        busResp = RS_OKAY;
        expIdx = dataIdx; dataPend = 0; fallback = 1; done = 1;
      end else if (mode == 1 && !done && expIdx == 2) begin
        busGrant = 1'b0; busReady = 1'b1; busResp = RS_OKAY;
        fallback = 1; dataPend = 0;
        #1 check(busTrans == TR_IDLE, "R9", "trans without grant", 32'(busTrans), 32'(TR_IDLE));
        dropCnt++;
        if (dropCnt == 3) done = 1;
        @(negedge clk);
      end else begin
        busGrant = 1'b1; busResp = RS_OKAY;
        busReady = (($urandom % 4) != 0);
        #1;
        if (expIdx < n) begin
          eTrans = (fallback || expIdx == 0) ? TR_NONSEQ : TR_SEQ;
          check(busTrans == eTrans, fallback ? "R9/R10" : "R7", "trans", 32'(busTrans), 32'(eTrans));
          check(busAddr == expAddr(k, a, expIdx), (n > 1) ? {tg, "/R6/R8"} : "R5",
                "address", busAddr, expAddr(k, a, expIdx));
          check(busBurst == (fallback ? 3'b000 : expBurst(k)), tg, "burst",
                32'(busBurst), 32'(fallback ? 3'b000 : expBurst(k)));
          check(busSize == eSize, (n > 1) ? "R4" : "R5", "size", 32'(busSize), 32'(eSize));
          check(busWrite == expWrite(k, w), tg, "direction", 32'(busWrite), 32'(expWrite(k, w)));
        end else begin
          check(busTrans == TR_IDLE, "R7", "trans after last beat", 32'(busTrans), 32'(TR_IDLE));
        end
        if (busReady) begin
          if (expIdx < n) begin
            dataPend = 1; dataIdx = expIdx; expIdx++;
          end else begin
            dataPend = 0;
          end
        end
        @(negedge clk);
      end
    end
    check(guard < 400, tg, "request did not finish", 32'(guard), 32'd400);
    #1;
    check(reqReady == 1'b1, "R11", "reqReady after completion", 32'(reqReady), 32'h1);
    check(busTrans == TR_IDLE, "R7", "idle after completion", 32'(busTrans), 32'(TR_IDLE));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqKind = '0; reqWrite = 1'b0;
    reqSize = '0; busGrant = 1'b1; busReady = 1'b1; busResp = RS_OKAY;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(busTrans == TR_IDLE, "R7", "reset trans", 32'(busTrans), 32'(TR_IDLE));
    check(reqReady == 1'b1, "R11", "reset reqReady", 32'(reqReady), 32'h1);

    runReq(32'h0000_1003, KD_SINGLE, 1'b0, 2'b00, 0);   // R5 byte read
    runReq(32'h0000_2002, KD_SINGLE, 1'b1, 2'b01, 0);   // R5 halfword write
    runReq(32'h0000_3004, KD_SINGLE, 1'b0, 2'b10, 0);   // R5 word read
    runReq(32'h0000_4014, KD_LINEFILL, 1'b1, 2'b00, 0); // R1 mid-line wrap, R4 size forced
    runReq(32'h0000_5018, KD_FULL_WB, 1'b0, 2'b01, 0);  // R2 R6 crosses 32-byte boundary
    runReq(32'h0000_600C, KD_WRITE8, 1'b0, 2'b10, 0);   // R2
    runReq(32'h0000_701C, KD_HALF_WB, 1'b0, 2'b10, 0);  // R3 R6 crosses line
    runReq(32'h0000_8008, KD_WRITE4, 1'b0, 2'b10, 0);   // R3
    runReq(32'h0000_9036, KD_PREFETCH, 1'b1, 2'b10, 0); // R3 read, R4 low bits cleared
    runReq(32'h0000_A010, KD_FULL_WB, 1'b0, 2'b10, 1);  // R9 grant loss
    runReq(32'h0000_B01C, KD_LINEFILL, 1'b0, 2'b10, 2); // R10 retry
    runReq(32'h0000_C004, KD_HALF_WB, 1'b0, 2'b10, 3);  // R10 split
    runReq(32'h0000_D008, KD_WRITE4, 1'b0, 2'b10, 1);   // R9 grant loss on four-beat

    for (int i = 0; i < 60; i++) begin
      logic [2:0] k;
      int md;
      k = 3'($urandom % 7);
      md = 0;
      if (k != KD_SINGLE && ($urandom % 3) == 0) md = 1 + int'($urandom % 3);
      runReq($urandom, k, 1'($urandom), 2'($urandom % 3), md);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule